// File: doc/BRIEF.md
# Strobe-Latched Interrupt Byte Capture

This block lets add-on logic raise a host interrupt and pass one byte of cause information without making a bus access. An asynchronous load strobe, which rests high, is pulsed low and then high again. The rising edge is synchronized into the clock domain and detected. On that edge the eight asynchronous data inputs are stored in the byte that the host reads as the top byte of the fourth incoming mailbox, and the interrupt for that mailbox is set.

The host reads `rd_byte` to learn why the interrupt was raised. It then pulses `host_clr` to acknowledge it. While an interrupt is pending, any new strobe edge is discarded and is not held for later. The function works only when the surrounding mailbox logic asserts `irq_en`. This input stands for the incoming-mailbox-full interrupt being enabled with the fourth mailbox's top byte selected. When the boot-configuration input selects a byte-wide boot device, the function is switched off and the read byte is forced to zero.

Top module: `strobe_byte_capture`

## Requirements
- R1: A low-to-high transition of `strb_in` that is accepted sets `irq_out` and loads `data_in` into the capture byte. Both are visible after the third rising clock edge that follows the strobe's rise, which passes through a two-flop synchronizer, and `data_in` is sampled on that same edge.
- R2: The strobe rests high. A rise counts only after a low level has been seen since reset, so a strobe that stays high through and after reset never raises an interrupt.
- R3: While the interrupt is pending, further strobe rises are dropped. The capture byte keeps its value, and a dropped rise does not raise an interrupt after a later clear.
- R4: A one-cycle `host_clr` pulse ends the pending interrupt on the next clock edge. Later strobe rises are then accepted again.
- R5: While `irq_en` is 0, strobe rises are ignored: no interrupt is raised and the capture byte does not change. A rise seen while disabled is not replayed when `irq_en` returns to 1.
- R6: While `bytewide_boot` is 1, strobe rises are ignored, `irq_out` is 0 and `rd_byte` reads 0x00. When `bytewide_boot` returns to 0, `rd_byte` again shows the byte held from before.
- R7: After reset `irq_out` is 0 and `rd_byte` is 0x00. Outside byte-wide boot mode, `rd_byte` shows the last byte captured and holds it until the next accepted rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| strb_in | input | 1 | Asynchronous load strobe, rests high; its rising edge captures data |
| data_in | input | 8 | Asynchronous cause byte, sampled on the detected strobe rise |
| irq_en | input | 1 | Mailbox-full interrupt enabled with this byte selected |
| bytewide_boot | input | 1 | 1 = byte-wide boot device selected; the feature is disabled |
| host_clr | input | 1 | One-cycle pulse from the host clearing the pending interrupt |
| irq_out | output | 1 | Interrupt request toward the host |
| rd_byte | output | 8 | Byte returned for host reads of this mailbox byte |

## Verification
An accepted strobe rise shows up on `irq_out` and `rd_byte` after the third clock edge that follows it: two edges in the synchronizer and one in the edge-detect and capture stage. A clear shows up after the next edge. The enable and boot-mode gating of the outputs acts within the same cycle. The bench drives every input just after a falling edge. A behavioural model steps once on every rising edge and tracks the strobe delay with a queue. Both outputs are compared with that model three nanoseconds after each rising edge, so each result is checked in exactly the cycle it is due. Directed checks at the end of each scenario confirm the absolute values.

// File: rtl/strobe_cap_pkg.sv
package strobe_cap_pkg;
  localparam int unsigned CAP_W      = 8;
  localparam int unsigned SYNC_DEPTH = 2;

  typedef enum logic {
    BOOT_NOT_BYTEWIDE = 1'b0,
    BOOT_BYTEWIDE     = 1'b1
  } boot_mode_e;
endpackage

// File: rtl/scap_sync.sv
module scap_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] shift_q;
  logic [STAGES-1:0] shift_d;

  always_comb begin
    shift_d = {shift_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= {STAGES{RST_VAL}};
    end else begin
      shift_q <= shift_d;
    end
  end

  assign q = shift_q[STAGES-1];
endmodule

// File: rtl/scap_edge.sv
module scap_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic rise
);
  logic prev_q, prev_d;
  logic armed_q, armed_d;

  always_comb begin
    prev_d  = lvl;
    armed_d = armed_q | ~lvl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= 1'b1;
      armed_q <= 1'b0;
    end else begin
      prev_q  <= prev_d;
      armed_q <= armed_d;
    end
  end

  assign rise = armed_q & lvl & ~prev_q;

  // R1: one strobe rise gives one single-cycle pulse
  assert_single_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/scap_capture.sv
module scap_capture #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rise,
  input  logic [W-1:0] data_in,
  input  logic         enable,
  input  logic         bytewide,
  input  logic         clr,
  output logic         pending,
  output logic [W-1:0] byte_val
);
  logic         pend_q, pend_d;
  logic [W-1:0] byte_q, byte_d;
  logic         feature_on;
  logic         accept;
  logic         byte_ce;

  always_comb begin
    feature_on = enable & ~bytewide;
    accept     = rise & feature_on & ~pend_q;
    byte_ce    = accept;
    pend_d     = pend_q;
    if (accept) begin
      pend_d = 1'b1;
    end else if (clr) begin
      pend_d = 1'b0;
    end
    byte_d = byte_ce ? data_in : byte_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      byte_q <= '0;
    end else begin
      pend_q <= pend_d;
      if (byte_ce) begin
        byte_q <= byte_d;
      end
    end
  end

  assign pending  = pend_q;
  assign byte_val = byte_q;

  assert_capture_R1: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (pend_q && byte_q == $past(data_in)));

  assert_lockout_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !clr) |=> (pend_q && $stable(byte_q)));

  assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && clr) |=> !pend_q);

  // R5 and R6: a disabled feature neither loads nor raises
  assert_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(enable && !bytewide) |=> ($stable(byte_q) && !$rose(pend_q)));
endmodule

// File: rtl/strobe_byte_capture.sv
module strobe_byte_capture
  import strobe_cap_pkg::*;
#(
  parameter int unsigned DATA_W      = CAP_W,
  parameter int unsigned SYNC_STAGES = SYNC_DEPTH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strb_in,
  input  logic [DATA_W-1:0] data_in,
  input  logic              irq_en,
  input  logic              bytewide_boot,
  input  logic              host_clr,
  output logic              irq_out,
  output logic [DATA_W-1:0] rd_byte
);
  logic       rst_n_int;
  logic       strb_sync;
  logic       strb_rise;
  logic       pend;
  logic [DATA_W-1:0] cap_byte;
  boot_mode_e mode;

  // reset: asserted asynchronously, released after SYNC_STAGES edges
  scap_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_n_int)
  );

  // strobe rests high, so the synchronizer resets to 1
  scap_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_strb_sync (
    .clk(clk), .rst_n(rst_n_int), .d(strb_in), .q(strb_sync)
  );

  scap_edge u_edge (
    .clk(clk), .rst_n(rst_n_int), .lvl(strb_sync), .rise(strb_rise)
  );

  scap_capture #(.W(DATA_W)) u_cap (
    .clk(clk), .rst_n(rst_n_int), .rise(strb_rise), .data_in(data_in),
    .enable(irq_en), .bytewide(bytewide_boot), .clr(host_clr),
    .pending(pend), .byte_val(cap_byte)
  );

  always_comb begin
    mode    = boot_mode_e'(bytewide_boot);
    irq_out = pend & irq_en & (mode == BOOT_NOT_BYTEWIDE);
    rd_byte = (mode == BOOT_BYTEWIDE) ? '0 : cap_byte;
  end

  assert_bootzero_R6: assert property (@(posedge clk) disable iff (!rst_n_int)
    bytewide_boot |-> (rd_byte == '0 && !irq_out));
endmodule

// File: tb/strobe_byte_capture_test.sv
module strobe_byte_capture_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       strb_in;
  logic [7:0] data_in;
  logic       irq_en;
  logic       bytewide_boot;
  logic       host_clr;
  logic       irq_out;
  logic [7:0] rd_byte;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  string phase = "R7";

  always #5 clk = ~clk;

  strobe_byte_capture uut (
    .clk(clk), .rst_n(rst_n), .strb_in(strb_in), .data_in(data_in),
    .irq_en(irq_en), .bytewide_boot(bytewide_boot), .host_clr(host_clr),
    .irq_out(irq_out), .rd_byte(rd_byte)
  );

  // behavioural reference model
  int   rcnt = 0;
  bit   sq[$] = '{1'b1, 1'b1};
  bit   m_prev = 1, m_armed = 0, m_pend = 0;
  int   m_byte = 0;

  always @(posedge clk) begin
    bit r;
    if (!rst_n || rcnt < 2) begin
      if (!rst_n) rcnt = 0; else rcnt = rcnt + 1;
      sq = '{1'b1, 1'b1};
      m_prev = 1; m_armed = 0; m_pend = 0; m_byte = 0;
    end else begin
      r = m_armed && sq[1] && !m_prev;
      if (r && irq_en && !bytewide_boot && !m_pend) begin
        m_pend = 1;
        m_byte = int'(data_in);
      end else if (host_clr) begin
        m_pend = 0;
      end
      if (!sq[1]) m_armed = 1;
      m_prev = sq[1];
      sq.push_front(strb_in);
      void'(sq.pop_back());
    end
  end

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #3;
    check({phase, " irq"}, int'(irq_out),
          int'(m_pend && irq_en && !bytewide_boot));
    check({phase, " byte"}, int'(rd_byte), bytewide_boot ? 0 : m_byte);
  end

  task automatic pulse(input logic [7:0] v);
    @(negedge clk) strb_in = 1'b0;
    repeat (3) @(negedge clk);
    data_in = v;
    strb_in = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic clear_irq();
    @(negedge clk) host_clr = 1'b1;
    @(negedge clk) host_clr = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    rst_n = 0; strb_in = 1; data_in = 8'h00;
    irq_en = 1; bytewide_boot = 0; host_clr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (8) @(negedge clk);
    phase = "R7";
    check("R7 reset irq", int'(irq_out), 0);
    check("R7 reset byte", int'(rd_byte), 0);
    phase = "R2";  // strobe high since reset: no interrupt
    repeat (4) @(negedge clk);
    check("R2 no spurious irq", int'(irq_out), 0);

    phase = "R1";
    pulse(8'hA5);
    check("R1 irq set", int'(irq_out), 1);
    check("R1 byte A5", int'(rd_byte), 8'hA5);

    phase = "R3";
    pulse(8'h3C);
    check("R3 byte kept", int'(rd_byte), 8'hA5);

    phase = "R4";
    clear_irq();
    check("R4 irq cleared", int'(irq_out), 0);
    check("R7 byte held", int'(rd_byte), 8'hA5);
    phase = "R3";
    repeat (6) @(negedge clk);
    check("R3 dropped edge not queued", int'(irq_out), 0);

    phase = "R4";
    pulse(8'h5A);
    check("R4 accepted after clear", int'(rd_byte), 8'h5A);
    clear_irq();

    phase = "R5";
    irq_en = 0;
    pulse(8'hFF);
    check("R5 byte unchanged", int'(rd_byte), 8'h5A);
    irq_en = 1;
    repeat (4) @(negedge clk);
    check("R5 no late irq", int'(irq_out), 0);

    phase = "R6";
    bytewide_boot = 1;
    @(negedge clk);
    check("R6 read zero", int'(rd_byte), 0);
    pulse(8'h81);
    check("R6 irq low", int'(irq_out), 0);
    bytewide_boot = 0;
    repeat (2) @(negedge clk);
    check("R6 byte restored", int'(rd_byte), 8'h5A);
    check("R6 no irq after mode", int'(irq_out), 0);

    phase = "R1";
    pulse(8'hC3);
    check("R1 second capture", int'(rd_byte), 8'hC3);
    clear_irq();
    pulse(8'h00);
    check("R1 zero byte", int'(rd_byte), 0);
    check("R1 zero irq", int'(irq_out), 1);

    repeat (4) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule